// File: doc/BRIEF.md
# Reset and Interrupt Instruction Injector

This block sits between the instruction memory and the decode stage of a simple 32-bit single-cycle processor. In normal operation the fetched word from memory goes straight through to decode. When a reset or interrupt request arrives, a two-bit sequencer takes over the word that decode sees. It steers a four-input selector whose other three inputs are fixed instruction words, so these words enter the control path without any memory access.

A reset request starts a two-word sequence. The first word loads the stack-pointer register from address zero. The second loads the program counter from a PC-relative location. In the cycle the reset is accepted, the block also raises a strobe that clears the program counter on the next clock edge, so both loads execute from a known address.

An interrupt request injects a single branch-and-link with an offset of 8. A reset that arrives during interrupt entry overrides it. A separate synchronous initialisation input puts the sequencer into its idle state at power-on. The reset request itself is only an ordinary input to the sequencer.

Top module: `boot_irq_injector`

## Requirements
- R1: When `init` is high at a rising clock edge, the state becomes 00 whatever the other inputs are, and `pc_clr` is low while `init` is high.
- R2: In state 00, a high `rst_req` at the clock edge moves the state to 01, whatever the value of `irq_req`.
- R3: State 01 always moves to 10, and state 10 always moves to 00, whatever the values of `rst_req` and `irq_req`.
- R4: In state 00 with `rst_req` low, a high `irq_req` moves the state to 11. With both requests low, the state stays at 00.
- R5: In state 11, a high `rst_req` moves the state to 01. Otherwise the state moves to 00, whatever the value of `irq_req`.
- R6: `dec_word` depends only on the current state, and `seq_state` gives that state:
  - state 00: `imem_word`, unchanged;
  - state 01: the stack-pointer load word;
  - state 10: the PC load word;
  - state 11: the branch-and-link word.
- R7: `pc_clr` is high in a cycle exactly when `init` is low, `rst_req` is high and the state is 00 or 11. These are the cycles in which the state will move to 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| init | input | 1 | Synchronous power-on initialisation, active high |
| rst_req | input | 1 | Reset request, sampled as a sequencer input |
| irq_req | input | 1 | Interrupt request |
| imem_word | input | 32 | Instruction word fetched from memory |
| dec_word | output | 32 | Instruction word sent to decode |
| pc_clr | output | 1 | Clears the program counter on the next edge |
| seq_state | output | 2 | Current sequencer state |

## Verification
The bench goes after the following corner cases, and what a wrong design would do in each:
- Reset and interrupt asserted together in idle. A design with the wrong priority would inject the branch-and-link instead of starting the reset sequence.
- Reset arriving in state 11. A design that lets the interrupt entry finish would return to idle and lose the reset.
- Requests asserted during states 01 and 10. A design that samples them there would cut the reset sequence short or restart it.
- The PC-clear strobe. A design that widens it into later cycles, or drops it when reset arrives from state 11, would be caught here.
- The fixed words. Each is overridden with a distinct constant, so a swapped selector input shows up as a wrong word in the state where it appears.

// File: rtl/injector_pkg.sv
package injector_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_RST_SP = 2'b01,
    ST_RST_PC = 2'b10,
    ST_IRQ_BL = 2'b11
  } inj_state_e;

  localparam int INJ_STATE_W = 2;
  localparam int INJ_SRC_N   = 1 << INJ_STATE_W;
endpackage

// File: rtl/inj_seq_fsm.sv
module inj_seq_fsm
  import injector_pkg::*;
(
  input  logic       clk,
  input  logic       init,
  input  logic       rst_req,
  input  logic       irq_req,
  output inj_state_e state_q
);
  inj_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (rst_req)      state_d = ST_RST_SP;
        else if (irq_req) state_d = ST_IRQ_BL;
        else              state_d = ST_IDLE;
      end
      ST_RST_SP: state_d = ST_RST_PC;
      ST_RST_PC: state_d = ST_IDLE;
      ST_IRQ_BL: state_d = rst_req ? ST_RST_SP : ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (init) state_q <= ST_IDLE;
    else      state_q <= state_d;
  end
endmodule

// File: rtl/inj_word_mux.sv
module inj_word_mux
  import injector_pkg::*;
#(
  parameter int          WORD_W   = 32,
  parameter logic [31:0] SP_WORD  = 32'hE510_D000,
  parameter logic [31:0] PC_WORD  = 32'hE59F_F000,
  parameter logic [31:0] BL_WORD  = 32'hEB00_0000
) (
  input  logic [INJ_STATE_W-1:0] sel,
  input  logic [WORD_W-1:0]      mem_word,
  output logic [WORD_W-1:0]      out_word
);
  logic [WORD_W-1:0] src [INJ_SRC_N];

  for (genvar i = 0; i < INJ_SRC_N; i++) begin : g_src
    if (i == 0) begin : g_mem
      assign src[i] = mem_word;
    end else if (i == 1) begin : g_sp
      assign src[i] = SP_WORD[WORD_W-1:0];
    end else if (i == 2) begin : g_pc
      assign src[i] = PC_WORD[WORD_W-1:0];
    end else begin : g_bl
      assign src[i] = BL_WORD[WORD_W-1:0];
    end
  end

  assign out_word = src[sel];
endmodule

// File: rtl/pc_clear_gen.sv
module pc_clear_gen
  import injector_pkg::*;
(
  input  logic       init,
  input  logic       rst_req,
  input  inj_state_e state,
  output logic       pc_clr
);
  logic accepting;

  always_comb begin
    unique case (state)
      ST_IDLE, ST_IRQ_BL: accepting = 1'b1;
      default:            accepting = 1'b0;
    endcase
  end

  assign pc_clr = !init && rst_req && accepting;
endmodule

// File: rtl/boot_irq_injector.sv
module boot_irq_injector
  import injector_pkg::*;
#(
  parameter int          WORD_W  = 32,
  parameter logic [31:0] SP_WORD = 32'hE510_D000,
  parameter logic [31:0] PC_WORD = 32'hE59F_F000,
  parameter logic [31:0] BL_WORD = 32'hEB00_0000
) (
  input  logic              clk,
  input  logic              init,
  input  logic              rst_req,
  input  logic              irq_req,
  input  logic [WORD_W-1:0] imem_word,
  output logic [WORD_W-1:0] dec_word,
  output logic              pc_clr,
  output logic [1:0]        seq_state
);
  inj_state_e state_q;

  inj_seq_fsm u_fsm (
    .clk     (clk),
    .init    (init),
    .rst_req (rst_req),
    .irq_req (irq_req),
    .state_q (state_q)
  );

  inj_word_mux #(
    .WORD_W  (WORD_W),
    .SP_WORD (SP_WORD),
    .PC_WORD (PC_WORD),
    .BL_WORD (BL_WORD)
  ) u_mux (
    .sel      (state_q),
    .mem_word (imem_word),
    .out_word (dec_word)
  );

  pc_clear_gen u_clr (
    .init    (init),
    .rst_req (rst_req),
    .state   (state_q),
    .pc_clr  (pc_clr)
  );

  assign seq_state = state_q;
endmodule

// File: rtl/inj_checker.sv
module inj_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              init,
  input logic              rst_req,
  input logic              irq_req,
  input logic [WORD_W-1:0] imem_word,
  input logic [WORD_W-1:0] dec_word,
  input logic              pc_clr,
  input logic [1:0]        seq_state
);
  // R1
  init_clears_chk: assert property (@(posedge clk) init |=> seq_state == 2'b00);

  // R1
  init_blocks_clr_chk: assert property (@(posedge clk) init |-> !pc_clr);

  // R2
  idle_reset_chk: assert property (@(posedge clk) disable iff (init)
    (seq_state == 2'b00 && rst_req) |=> seq_state == 2'b01);

  // R3
  sp_to_pc_chk: assert property (@(posedge clk) disable iff (init)
    seq_state == 2'b01 |=> seq_state == 2'b10);

  // R3
  pc_to_idle_chk: assert property (@(posedge clk) disable iff (init)
    seq_state == 2'b10 |=> seq_state == 2'b00);

  // R4
  idle_irq_chk: assert property (@(posedge clk) disable iff (init)
    (seq_state == 2'b00 && !rst_req && irq_req) |=> seq_state == 2'b11);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (init)
    (seq_state == 2'b00 && !rst_req && !irq_req) |=> seq_state == 2'b00);

  // R5
  irq_exit_chk: assert property (@(posedge clk) disable iff (init)
    (seq_state == 2'b11 && !rst_req) |=> seq_state == 2'b00);

  // R5
  irq_preempt_chk: assert property (@(posedge clk) disable iff (init)
    (seq_state == 2'b11 && rst_req) |=> seq_state == 2'b01);

  // R6
  passthru_chk: assert property (@(posedge clk) disable iff (init)
    seq_state == 2'b00 |-> dec_word == imem_word);

  // R7
  clr_leads_chk: assert property (@(posedge clk) disable iff (init)
    pc_clr |=> seq_state == 2'b01);

  // R7
  clr_quiet_chk: assert property (@(posedge clk) disable iff (init)
    (seq_state == 2'b01 || seq_state == 2'b10) |-> !pc_clr);
endmodule

bind boot_irq_injector inj_checker #(.WORD_W(WORD_W)) u_inj_chk (
  .clk       (clk),
  .init      (init),
  .rst_req   (rst_req),
  .irq_req   (irq_req),
  .imem_word (imem_word),
  .dec_word  (dec_word),
  .pc_clr    (pc_clr),
  .seq_state (seq_state)
);

// File: tb/boot_irq_injector_tb_top.sv
module boot_irq_injector_tb_top;
  localparam logic [31:0] W_SP = 32'hA1A1_0101;
  localparam logic [31:0] W_PC = 32'hB2B2_0202;
  localparam logic [31:0] W_BL = 32'hC3C3_0303;

  logic        clk = 1'b0;
  logic        init, rst_req, irq_req;
  logic [31:0] imem_word, dec_word;
  logic        pc_clr;
  logic [1:0]  seq_state;

  int n_checks = 0;
  int n_fail   = 0;
  logic [1:0] model_st;
  logic       model_valid = 1'b0;
  int unsigned seed_v;

  always #10 clk = ~clk;

  boot_irq_injector #(
    .SP_WORD (W_SP),
    .PC_WORD (W_PC),
    .BL_WORD (W_BL)
  ) dut_i (
    .clk       (clk),
    .init      (init),
    .rst_req   (rst_req),
    .irq_req   (irq_req),
    .imem_word (imem_word),
    .dec_word  (dec_word),
    .pc_clr    (pc_clr),
    .seq_state (seq_state)
  );

  function automatic logic [1:0] model_next(logic [1:0] s, logic i, logic r, logic q);
    if (i) return 2'b00;
    case (s)
      2'b00:   return r ? 2'b01 : (q ? 2'b11 : 2'b00);
      2'b01:   return 2'b10;
      2'b10:   return 2'b00;
      default: return r ? 2'b01 : 2'b00;
    endcase
  endfunction

  function automatic logic [31:0] model_word(logic [1:0] s, logic [31:0] m);
    case (s)
      2'b00:   return m;
      2'b01:   return W_SP;
      2'b10:   return W_PC;
      default: return W_BL;
    endcase
  endfunction

  function automatic logic model_clr(logic [1:0] s, logic i, logic r);
    return !i && r && (s == 2'b00 || s == 2'b11);
  endfunction

  function automatic string state_req(logic [1:0] prev_s, logic prev_i, logic prev_r);
    if (prev_i) return "R1";
    case (prev_s)
      2'b00:   return prev_r ? "R2" : "R4";
      2'b11:   return "R5";
      default: return "R3";
    endcase
  endfunction

  string last_tag = "R1";

  task automatic check_now();
    n_checks++;
    if (seq_state !== model_st) begin
      n_fail++;
      $display("FAIL %s seq_state actual=%b expected=%b", last_tag, seq_state, model_st);
    end
    n_checks++;
    if (dec_word !== model_word(model_st, imem_word)) begin
      n_fail++;
      $display("FAIL R6 dec_word actual=%h expected=%h", dec_word,
               model_word(model_st, imem_word));
    end
    n_checks++;
    if (pc_clr !== model_clr(model_st, init, rst_req)) begin
      n_fail++;
      $display("FAIL %s pc_clr actual=%b expected=%b", init ? "R1" : "R7", pc_clr,
               model_clr(model_st, init, rst_req));
    end
  endtask

  // drive at negedge, check, then advance the model over one rising edge
  task automatic step(logic i, logic r, logic q, logic [31:0] m);
    init = i; rst_req = r; irq_req = q; imem_word = m;
    #1;
    if (model_valid) check_now();
    @(posedge clk);
    last_tag = state_req(model_st, i, r);
    model_st = model_next(model_st, i, r, q);
    if (i) model_valid = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    init = 1'b1; rst_req = 1'b1; irq_req = 1'b1; imem_word = '0;
    model_st = 2'b00;
    @(negedge clk);
    // R1: initialisation with both requests high
    step(1'b1, 1'b1, 1'b1, 32'h1111_0000);
    step(1'b0, 1'b0, 1'b0, 32'h1234_5678);   // R6 passthrough in idle
    // R2: reset and interrupt together from idle, then R3 ignores requests
    step(1'b0, 1'b1, 1'b1, 32'h0BAD_F00D);
    step(1'b0, 1'b1, 1'b1, 32'hDEAD_BEEF);
    step(1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF);
    step(1'b0, 1'b0, 1'b0, 32'h0000_0000);
    // R4: interrupt alone, then R5 exit with interrupt still high
    step(1'b0, 1'b0, 1'b1, 32'h5555_AAAA);
    step(1'b0, 1'b0, 1'b1, 32'hAAAA_5555);
    step(1'b0, 1'b0, 1'b0, 32'h0F0F_0F0F);
    // R5: reset arriving in state 11 preempts, R7 strobe there
    step(1'b0, 1'b0, 1'b1, 32'h1);
    step(1'b0, 1'b1, 1'b0, 32'h2);
    step(1'b0, 1'b0, 1'b0, 32'h3);
    step(1'b0, 1'b0, 1'b0, 32'h4);
    // R1: init in the middle of the reset sequence
    step(1'b0, 1'b1, 1'b0, 32'h5);
    step(1'b1, 1'b1, 1'b1, 32'h6);
    step(1'b0, 1'b0, 1'b0, 32'h7);
    // constrained random
    seed_v = 32'd20240917;
    void'($urandom(seed_v));
    for (int k = 0; k < 2000; k++) begin
      logic i, r, q;
      i = ($urandom % 50) == 0;
      r = ($urandom % 4) == 0;
      q = ($urandom % 5) < 2;
      step(i, r, q, $urandom);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule